// File: doc/BRIEF.md
# Configuration Register File with Write Masks

This block holds a byte-addressed configuration space. It has a 64-byte standard header followed by a device-specific area. Every byte has two fixed masks, and the two never share a bit. The first mask marks the bits that an ordinary write replaces. The second marks the bits where writing a one clears the stored bit. Any bit outside both masks is read-only. Such a bit keeps its power-on value, which is either an identity constant or zero.

Software reaches the space through one write port and one read port. The write port takes a start address, up to four data bytes and a byte count. The read port returns four consecutive bytes, one clock after the address is presented. A synchronous function-reset input clears the software-controlled part of the command and status words, the cache line size byte and the interrupt line byte. The rest of the space is left as it is. Six hardware error inputs set individual status flags, and software later clears them with a write-one-to-clear write.

Top module: `cfg_space_regs`

## Requirements
- R1: After `rstN` is released, bytes 0..3 read as `DEV_ID`, least significant byte at address 0. Bytes 8..11 read as `CLASS_REV` in the same order. Every other byte reads zero.
- R2: A write stores byte lane i (`wrData[8*i+7:8*i]`) at address `wrAddr+i` for every i below `wrLen`. A `wrLen` of 0 writes nothing, and a `wrLen` above 4 writes four bytes. `rdData` byte j carries the byte at `rdAddr+j`. `rdData` is registered, so it reflects the address of the previous cycle and the contents before any write in that same cycle.
- R3: For each written byte, only the bits in its write mask take the new data. The identity bytes 0..3 and 8..11 ignore all writes.
- R4: Command word (byte 4 = bits 7:0, byte 5 = bits 15:8): bits 0, 1, 2 and 10 are writable. Bit 8 is writable when `SERR_WRITABLE` is 1, which is the default. All other command bits read zero.
- R5: Status word (byte 6 = bits 7:0, byte 7 = bits 15:8): bits 8, 11, 12, 13, 14 and 15 are write-one-to-clear. Writing 1 clears such a bit and writing 0 leaves it unchanged. All other status bits are read-only zero.
- R6: Every byte from address 64 up to `CFG_BYTES-1` is fully writable.
- R7: Write lanes whose address would reach `CFG_BYTES` or beyond are dropped. Read lanes at such addresses return zero.
- R8: A cycle with `softRst` high clears these bits: command bits 0, 1, 2, 8 and 10, status bits 8 and 11..15, and the bytes at 0x0C and 0x3C. This clear overrides a write to those bits in the same cycle. Other bytes are untouched.
- R9: `errSet[0]` sets status bit 8, and `errSet[5:1]` set status bits 15:11. A set is visible on the next read. When a set meets a write-one-to-clear or `softRst` on the same bit in the same cycle, the set wins.
- R10: The cache line size byte (0x0C) and the interrupt line byte (0x3C) are fully writable. The other header bytes hold no writable bits except those named in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| softRst | input | 1 | Synchronous function reset of the masked header state |
| wrEn | input | 1 | Write request for this cycle |
| wrAddr | input | ADDR_W | Address of write lane 0 |
| wrData | input | 32 | Write data, lane 0 in bits 7:0 |
| wrLen | input | 3 | Number of bytes to write |
| rdAddr | input | ADDR_W | Address of read lane 0 |
| rdData | output | 32 | Read data, one cycle after rdAddr |
| errSet | input | 6 | Hardware error flags to set in the status word |

## Verification
Writes, soft resets and error sets take effect at the same rising edge that samples them. The read data is registered, so a result becomes visible one edge after the read address is presented. The bench therefore applies each stimulus on a falling edge and presents the read address on a later falling edge. It samples `rdData` on the falling edge that follows, which is exactly one register stage later. Collision cases drive the competing inputs in the same cycle, for example an error set with a clear write, or `softRst` with a write. The result is read back only after that single edge.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int LANES    = 4;
  localparam int AW_MAX   = 12;
  localparam int HDR_SIZE = 64;
  localparam int CMD_LO   = 4;
  localparam int CMD_HI   = 5;
  localparam int STAT_HI  = 7;
  localparam int CLS_BYTE = 12;
  localparam int ILN_BYTE = 60;

  typedef struct packed {
    logic [LANES-1:0]             laneVal;
    logic [LANES-1:0][AW_MAX-1:0] laneAddr;
    logic [LANES-1:0][7:0]        laneData;
    logic                         softClr;
    logic [7:0]                   statSet;
    logic [AW_MAX-1:0]            rdAddr;
  } cfgStb_t;

  function automatic logic [7:0] wmaskOf(int idx, bit serrWr);
    if (idx >= HDR_SIZE) return 8'hFF;
    case (idx)
      CMD_LO:             return 8'h07;
      CMD_HI:             return serrWr ? 8'h05 : 8'h04;
      CLS_BYTE, ILN_BYTE: return 8'hFF;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] w1cOf(int idx);
    return (idx == STAT_HI) ? 8'hF9 : 8'h00;
  endfunction

  function automatic logic [7:0] clrOf(int idx, bit serrWr);
    if (idx == CLS_BYTE || idx == ILN_BYTE) return 8'hFF;
    if (idx >= CMD_LO && idx <= STAT_HI) return wmaskOf(idx, serrWr) | w1cOf(idx);
    return 8'h00;
  endfunction

  function automatic logic [7:0] initOf(int idx, logic [31:0] devId, logic [31:0] clsRev);
    if (idx >= 0 && idx < 4) return devId[8*idx +: 8];
    if (idx >= 8 && idx < 12) return clsRev[8*(idx-8) +: 8];
    return 8'h00;
  endfunction

endpackage

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
  import cfg_space_pkg::*;
#(
  parameter int CFG_BYTES = 256,
  localparam int ADDR_W = $clog2(CFG_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [2:0]        wrLen,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [5:0]        errSet,
  output cfgStb_t           stb
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(CFG_BYTES);

  logic [LANES-1:0][ADDR_W:0] laneSum;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneSum[i] = {1'b0, wrAddr} + (ADDR_W+1)'(i);
    assign stb.laneVal[i]  = wrEn && (wrLen > 3'(i)) && (laneSum[i] < LIMIT);
    assign stb.laneAddr[i] = AW_MAX'(laneSum[i][ADDR_W-1:0]);
    assign stb.laneData[i] = wrData[8*i +: 8];
  end

  assign stb.softClr = softRst;
  assign stb.statSet = {errSet[5:1], 2'b00, errSet[0]};
  assign stb.rdAddr  = AW_MAX'(rdAddr);

  AST_NO_LANE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || wrLen == 3'd0) |-> stb.laneVal == '0); // R2

  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $countones(stb.laneVal) <= int'(wrLen)); // R7

endmodule

// File: rtl/cfg_space_datapath.sv
module cfg_space_datapath
  import cfg_space_pkg::*;
#(
  parameter int          CFG_BYTES     = 256,
  parameter bit          SERR_WRITABLE = 1'b1,
  parameter logic [31:0] DEV_ID        = 32'h0000_0000,
  parameter logic [31:0] CLASS_REV     = 32'h0000_0000,
  localparam int ADDR_W = $clog2(CFG_BYTES)
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStb_t     stb,
  output logic [31:0] rdData
);

  localparam logic [AW_MAX:0] LIMIT    = (AW_MAX+1)'(CFG_BYTES);
  localparam logic [7:0]      STAT_W1C = w1cOf(STAT_HI);
  localparam logic [7:0]      CMD_HI_W = wmaskOf(CMD_HI, SERR_WRITABLE);

  logic [7:0] memArr [CFG_BYTES];

  for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byte
    localparam logic [7:0] WM   = wmaskOf(b, SERR_WRITABLE);
    localparam logic [7:0] W1   = w1cOf(b);
    localparam logic [7:0] CLRM = clrOf(b, SERR_WRITABLE);
    localparam logic [7:0] INIT = initOf(b, DEV_ID, CLASS_REV);
    localparam logic [7:0] SETM = (b == STAT_HI) ? 8'hFF : 8'h00;

    logic       hit;
    logic [7:0] dIn;
    logic [7:0] byteQ;
    logic [7:0] byteD;

    always_comb begin
      hit = 1'b0;
      dIn = 8'h00;
      for (int l = 0; l < LANES; l++) begin
        if (stb.laneVal[l] && stb.laneAddr[l] == AW_MAX'(b)) begin
          hit = 1'b1;
          dIn = stb.laneData[l];
        end
      end
    end

    always_comb begin
      byteD = byteQ;
      if (hit) begin
        byteD = (byteQ & ~WM) | (dIn & WM);
        byteD = byteD & ~(dIn & W1);
      end
      if (stb.softClr) byteD = byteD & ~CLRM;
      byteD = byteD | (stb.statSet & SETM);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) byteQ <= INIT;
      else       byteQ <= byteD;
    end

    assign memArr[b] = byteQ;
  end

  // read path
  logic [31:0] rdNext;
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      logic [AW_MAX:0] idx;
      idx = {1'b0, stb.rdAddr} + (AW_MAX+1)'(j);
      rdNext[8*j +: 8] = (idx < LIMIT) ? memArr[idx[ADDR_W-1:0]] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  // status-byte write observed separately for checking
  logic       statHit;
  logic [7:0] statData;
  always_comb begin
    statHit  = 1'b0;
    statData = 8'h00;
    for (int l = 0; l < LANES; l++) begin
      if (stb.laneVal[l] && stb.laneAddr[l] == AW_MAX'(STAT_HI)) begin
        statHit  = 1'b1;
        statData = stb.laneData[l];
      end
    end
  end

  AST_ID_READONLY: assert property (@(posedge clk) disable iff (!rstN)
    stb.laneVal != '0 |=> $stable({memArr[3], memArr[2], memArr[1], memArr[0]})); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (statHit && stb.statSet == '0) |=> (memArr[STAT_HI] & $past(statData & STAT_W1C)) == '0); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.statSet != '0 |=> (memArr[STAT_HI] & $past(stb.statSet)) == $past(stb.statSet)); // R9

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.softClr && stb.statSet == '0) |=>
      (memArr[CMD_LO][2:0] == 3'b000) && ((memArr[CMD_HI] & CMD_HI_W) == '0) &&
      ((memArr[STAT_HI] & STAT_W1C) == '0) &&
      (memArr[CLS_BYTE] == '0) && (memArr[ILN_BYTE] == '0)); // R8

  AST_READ_END_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdAddr == AW_MAX'(CFG_BYTES-1) |=> rdData[31:8] == '0); // R7

endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfg_space_pkg::*;
#(
  parameter int          CFG_BYTES     = 256,
  parameter bit          SERR_WRITABLE = 1'b1,
  parameter logic [31:0] DEV_ID        = 32'h7E21_19C4,
  parameter logic [31:0] CLASS_REV     = 32'h0280_0003,
  localparam int ADDR_W = $clog2(CFG_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [2:0]        wrLen,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  input  logic [5:0]        errSet
);

  cfgStb_t stb;

  cfg_space_ctrl #(.CFG_BYTES(CFG_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wrLen(wrLen), .rdAddr(rdAddr), .errSet(errSet), .stb(stb)
  );

  cfg_space_datapath #(
    .CFG_BYTES(CFG_BYTES), .SERR_WRITABLE(SERR_WRITABLE),
    .DEV_ID(DEV_ID), .CLASS_REV(CLASS_REV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdData(rdData)
  );

endmodule

// File: tb/tb_cfg_space_regs.sv
`timescale 1ns/1ps
module tb_cfg_space_regs;

  localparam int          NBYTES = 256;
  localparam logic [31:0] ID_V   = 32'hA5C3_1F08;
  localparam logic [31:0] CR_V   = 32'h0C03_2011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  wrLen = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [5:0]  errSet = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_space_regs #(.CFG_BYTES(NBYTES), .SERR_WRITABLE(1'b1), .DEV_ID(ID_V), .CLASS_REV(CR_V)) dut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wrLen(wrLen), .rdAddr(rdAddr), .rdData(rdData), .errSet(errSet)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] n);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrLen = n;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    rdAddr = a;
    @(negedge clk);
    v = rdData;
  endtask

  task automatic pulseErr(input logic [5:0] e);
    @(negedge clk);
    errSet = e;
    @(negedge clk);
    errSet = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R1 id bytes", v, ID_V);
    rd(8'h08, v); chk("R1 class bytes", v, CR_V);
    rd(8'h04, v); chk("R1 cmd/status zero", v, 32'h0);
    rd(8'h40, v); chk("R1 device area zero", v, 32'h0);
  endtask

  task automatic t_dev_area;
    logic [31:0] v;
    wr(8'h40, 32'hDEADBEEF, 3'd4); rd(8'h40, v); chk("R6 full word", v, 32'hDEADBEEF);
    rd(8'h41, v); chk("R2 little-endian offset read", v, 32'h00DEADBE);
    wr(8'h44, 32'hAABB1234, 3'd2); rd(8'h44, v); chk("R2 two-byte write", v, 32'h00001234);
    wr(8'h48, 32'h99887766, 3'd1); rd(8'h48, v); chk("R2 one-byte write", v, 32'h00000066);
    wr(8'h4C, 32'h11223344, 3'd0); rd(8'h4C, v); chk("R2 zero-length write", v, 32'h0);
    wr(8'h50, 32'hCAFEF00D, 3'd7); rd(8'h50, v); chk("R2 length above four", v, 32'hCAFEF00D);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    wr(8'h00, 32'hFFFFFFFF, 3'd4); rd(8'h00, v); chk("R3 id ignores write", v, ID_V);
    wr(8'h08, 32'h00000000, 3'd4); rd(8'h08, v); chk("R3 class ignores write", v, CR_V);
  endtask

  task automatic t_command;
    logic [31:0] v;
    wr(8'h04, 32'h0000FFFF, 3'd2); rd(8'h04, v); chk("R4 command writable bits", v, 32'h00000507);
    wr(8'h04, 32'h00000000, 3'd2); rd(8'h04, v); chk("R4 command cleared by write", v, 32'h0);
  endtask

  task automatic t_header_bytes;
    logic [31:0] v;
    wr(8'h0C, 32'hFFFFFFFF, 3'd4); rd(8'h0C, v); chk("R10 cache line byte only", v, 32'h000000FF);
    wr(8'h3C, 32'hFFFFFFFF, 3'd4); rd(8'h3C, v); chk("R10 interrupt line byte only", v, 32'h000000FF);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    pulseErr(6'h3F); rd(8'h04, v); chk("R9 all error bits set", v, 32'hF9000000);
    wr(8'h06, 32'h00000900, 3'd2); rd(8'h04, v); chk("R5 w1c bits 8 and 11", v, 32'hF0000000);
    wr(8'h06, 32'h00000000, 3'd2); rd(8'h04, v); chk("R5 writing zero keeps", v, 32'hF0000000);
    wr(8'h06, 32'h0000FFFF, 3'd2); rd(8'h04, v); chk("R5 w1c remaining", v, 32'h0);
    pulseErr(6'h02); rd(8'h04, v); chk("R9 errSet1 to bit 11", v, 32'h08000000);
    wr(8'h06, 32'h0000FF00, 3'd2);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'h06; wrData = 32'h00000100; wrLen = 3'd2; errSet = 6'h01;
    @(negedge clk);
    wrEn = 1'b0; errSet = '0;
    rd(8'h04, v); chk("R9 set beats w1c", v, 32'h01000000);
    wr(8'h06, 32'h00000100, 3'd2); rd(8'h04, v); chk("R5 later clear", v, 32'h0);
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    wr(8'h04, 32'h00000507, 3'd2);
    wr(8'h0C, 32'h00000055, 3'd1);
    wr(8'h3C, 32'h00000066, 3'd1);
    wr(8'h60, 32'h13579BDF, 3'd4);
    pulseErr(6'h3F);
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    rd(8'h04, v); chk("R8 cmd/status cleared", v, 32'h0);
    rd(8'h0C, v); chk("R8 cache line cleared", v, 32'h0);
    rd(8'h3C, v); chk("R8 interrupt line cleared", v, 32'h0);
    rd(8'h60, v); chk("R8 device area kept", v, 32'h13579BDF);
    rd(8'h00, v); chk("R8 id kept", v, ID_V);
    @(negedge clk);
    softRst = 1'b1; wrEn = 1'b1; wrAddr = 8'h0C; wrData = 32'h000000AA; wrLen = 3'd1;
    @(negedge clk);
    softRst = 1'b0; wrEn = 1'b0;
    rd(8'h0C, v); chk("R8 soft reset beats write", v, 32'h0);
    @(negedge clk);
    softRst = 1'b1; errSet = 6'h20;
    @(negedge clk);
    softRst = 1'b0; errSet = '0;
    rd(8'h04, v); chk("R9 set beats soft reset", v, 32'h80000000);
    wr(8'h06, 32'h00008000, 3'd2);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(8'hFE, 32'h44332211, 3'd4);
    rd(8'hFC, v); chk("R7 tail bytes written", v, 32'h22110000);
    rd(8'hFE, v); chk("R7 read past end zero", v, 32'h00002211);
    rd(8'hFF, v); chk("R7 last byte read", v, 32'h00000022);
    rd(8'h00, v); chk("R7 no wrap to start", v, ID_V);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_dev_area();
    t_readonly();
    t_command();
    t_header_bytes();
    t_w1c();
    t_set_wins();
    t_soft_reset();
    t_edge();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1..all actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule